// File: doc/BRIEF.md
# JTAG Scan Shift Engine

This block is the host side of a JTAG link. From the system clock it makes a divided test clock, drives the mode-select and data-in lines, and samples the data-out line. It shifts one bit string of 1 to 32 bits through whichever target register the TAP controller has selected. Each transfer carries its own bit count, a bit-order flag and two exit-control flags. The captured word comes back on `result` together with a one-cycle `done` pulse.

A small built-in sequencer reads the 32-bit identification code. It starts from Run-Test/Idle and walks the TAP into the instruction-shift state. It loads the identification opcode, 5 or 7 bits wide, LSB first and returns to idle. It then walks into the data-shift state and clocks 32 zeros LSB first. The captured value is presented on `id_code` with an `id_done` pulse. Plain transfers assume the TAP already sits in a shift state.

Top module: `jtag_scan_master`

## Requirements
- R1: After reset, tck=0, tms=0, tdi=1, busy=0, done=0, result=0, id_done=0 and id_code=0.
- R2: While busy, tck runs with a low phase and a high phase of HALF_DIV system clocks each, low phase first. tms and tdi change only on the system edge where tck falls, or at acceptance while tck is low. tdo is sampled on the system edge where tck rises.
- R3: With lsb_first=1, bit 0 of shift_word is sent first. For an n-bit transfer, result bit k holds the k-th sampled tdo bit, counting from 0.
- R4: With lsb_first=0, bit n-1 of shift_word is sent first. The first sampled tdo bit ends in result bit n-1 and the last in bit 0. Result bits n and above are 0.
- R5: With no_end=0, tms is 1 with the last data bit, and one more tck is issued with tms=1 (Exit1 to Update). Unless no_idle=1, a further tck is issued with tms=0, ending in Run-Test/Idle. With no_idle=1 the TAP is left in Update.
- R6: With no_end=1, tms stays 0 for every bit, no extra tck is issued and no_idle has no effect. The TAP stays in the shift state, so a following transfer continues the same register.
- R7: After the last data bit, tdi is driven to 1 and stays 1 whenever the block is not busy.
- R8: done is a one-cycle pulse. In that cycle result holds the captured word and busy is already 0.
- R9: A start while busy is ignored. A start with shift_len of 0 or above 32 is ignored.
- R10: On id_start the sequencer does the following, then sets id_code and pulses id_done one cycle after the final done. It issues tms 1,1,0,0, then sends ir_len bits of the opcode LSB first and exits to idle. It then issues tms 1,0,0 and sends 32 zero bits LSB first, ending in Run-Test/Idle.
- R11: ir_len values 5 and 7 are both accepted. The count of tck pulses in an identification read is 43 + ir_len.
- R12: id_start while busy is ignored. When start and id_start arrive in the same cycle, the identification read wins and the plain start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a plain transfer |
| shift_word | input | MAX_BITS | Bits to send |
| shift_len | input | LEN_W | Bit count, 1 to MAX_BITS |
| lsb_first | input | 1 | 1: bit 0 first; 0: top bit first |
| no_end | input | 1 | Stay in the shift state after the transfer |
| no_idle | input | 1 | Stop in Update instead of Run-Test/Idle |
| id_start | input | 1 | Request an identification read |
| ir_len | input | IR_LEN_W | Instruction register length, 5 or 7 |
| tdo | input | 1 | Target data out |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Target data in |
| busy | output | 1 | Transfer or identification read in progress |
| done | output | 1 | One-cycle pulse at the end of each transfer |
| result | output | MAX_BITS | Captured word |
| id_done | output | 1 | One-cycle pulse when id_code is valid |
| id_code | output | MAX_BITS | Captured identification code |

## Verification
The bench drives a full model of the TAP state machine with a 32-bit data register and an instruction register of 5 or 7 bits. Each transfer is therefore judged on three results: the captured word, the bits that landed in the target register, and the state and tck count it ends with. The vectors pair each bit order with lengths of 1, 2, 6, 8, 11 and 32 and with all exit-flag combinations. This separates a reversed order, a lost top or bottom bit, and a missing or extra exit clock. A chained pair of 16-bit transfers shows that no_end really keeps the shift state open. Identification reads with both instruction lengths check the navigation patterns, and the ignored-request cases check that no stray clocks reach the target.

// File: rtl/jtag_scan_pkg.sv
package jtag_scan_pkg;
  localparam int unsigned LEAD_W   = 3;
  localparam int unsigned LEAD_MAX = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_EXIT_UPD,
    ST_EXIT_RTI
  } scan_state_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_IR,
    SQ_DR
  } seq_state_t;

  // Navigation patterns, bit 0 issued first
  localparam logic [LEAD_MAX-1:0] PAT_TO_SHIFT_IR = 4'b0011;
  localparam logic [LEAD_MAX-1:0] PAT_TO_SHIFT_DR = 4'b0001;
endpackage

// File: rtl/jtag_tck_div.sv
module jtag_tck_div #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tck,
  output logic rise,
  output logic fall
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = en && (cnt == CW'(HALF_DIV - 1));
  assign rise = wrap && !tck;
  assign fall = wrap && tck;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      tck <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      tck <= ~tck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/jtag_scan_shifter.sv
module jtag_scan_shifter
  import jtag_scan_pkg::*;
#(
  parameter int unsigned MAX_BITS = 32,
  parameter int unsigned LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [MAX_BITS-1:0] req_word,
  input  logic [LEN_W-1:0]    req_len,
  input  logic                req_lsb,
  input  logic                req_no_end,
  input  logic                req_no_idle,
  input  logic [LEAD_W-1:0]   req_lead_n,
  input  logic [LEAD_MAX-1:0] req_lead_pat,
  input  logic                tdo,
  input  logic                rise,
  input  logic                fall,
  output logic                tms,
  output logic                tdi,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] result
);
  scan_state_t         state;
  logic [MAX_BITS-1:0] word, mask_q, top_q, m_in, t_in, shifted;
  logic [LEN_W-1:0]    left;
  logic [LEAD_W-1:0]   lead_left;
  logic [LEAD_MAX-1:0] lead_sr;
  logic                lsb_q, ne_q, ni_q;
  logic                len_ok, accept, first_in, nxt_bit, fin;

  assign m_in     = {MAX_BITS{1'b1}} >> (LEN_W'(MAX_BITS) - req_len);
  assign t_in     = m_in ^ (m_in >> 1);
  assign len_ok   = (req_len != '0) && (req_len <= LEN_W'(MAX_BITS));
  assign accept   = go && (state == ST_IDLE) && len_ok;
  assign first_in = req_lsb ? req_word[0] : |(req_word & t_in);
  assign nxt_bit  = lsb_q ? word[0] : |(word & top_q);
  assign shifted  = lsb_q ? ((word >> 1) | (tdo ? top_q : '0))
                          : (((word << 1) | MAX_BITS'(tdo)) & mask_q);
  assign fin      = fall && (((state == ST_SHIFT) && (left == LEN_W'(1)) && ne_q) ||
                             ((state == ST_EXIT_UPD) && ni_q) ||
                             (state == ST_EXIT_RTI));
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      word      <= '0;
      mask_q    <= '0;
      top_q     <= '0;
      left      <= '0;
      lead_left <= '0;
      lead_sr   <= '0;
      lsb_q     <= 1'b0;
      ne_q      <= 1'b0;
      ni_q      <= 1'b0;
      tms       <= 1'b0;
      tdi       <= 1'b1;
      done      <= 1'b0;
      result    <= '0;
    end else begin
      done <= 1'b0;
      if (fin) begin
        state  <= ST_IDLE;
        done   <= 1'b1;
        result <= word;
        tms    <= 1'b0;
        tdi    <= 1'b1;
      end else begin
        unique case (state)
          ST_IDLE: if (accept) begin
            word   <= req_word & m_in;
            mask_q <= m_in;
            top_q  <= t_in;
            left   <= req_len;
            lsb_q  <= req_lsb;
            ne_q   <= req_no_end;
            ni_q   <= req_no_idle;
            if (req_lead_n != '0) begin
              state     <= ST_LEAD;
              lead_left <= req_lead_n;
              lead_sr   <= req_lead_pat >> 1;
              tms       <= req_lead_pat[0];
              tdi       <= 1'b1;
            end else begin
              state <= ST_SHIFT;
              tms   <= (req_len == LEN_W'(1)) && !req_no_end;
              tdi   <= first_in;
            end
          end
          ST_LEAD: if (fall) begin
            if (lead_left > LEAD_W'(1)) begin
              lead_left <= lead_left - 1'b1;
              tms       <= lead_sr[0];
              lead_sr   <= lead_sr >> 1;
            end else begin
              state <= ST_SHIFT;
              tms   <= (left == LEN_W'(1)) && !ne_q;
              tdi   <= nxt_bit;
            end
          end
          ST_SHIFT: begin
            if (rise) begin
              word <= shifted;
            end else if (fall) begin
              left <= left - 1'b1;
              if (left > LEN_W'(1)) begin
                tdi <= nxt_bit;
                tms <= (left == LEN_W'(2)) && !ne_q;
              end else begin
                tdi   <= 1'b1;
                state <= ST_EXIT_UPD;
                tms   <= 1'b1;
              end
            end
          end
          ST_EXIT_UPD: if (fall) begin
            state <= ST_EXIT_RTI;
            tms   <= 1'b0;
          end
          ST_EXIT_RTI: ;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/jtag_idcode_seq.sv
module jtag_idcode_seq
  import jtag_scan_pkg::*;
#(
  parameter int unsigned MAX_BITS  = 32,
  parameter int unsigned LEN_W     = $clog2(MAX_BITS + 1),
  parameter int unsigned IR_LEN_W  = 3,
  parameter int unsigned IR_MAX    = 7,
  parameter logic [IR_MAX-1:0] IDCODE_OP = 7'h1E
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                id_start,
  input  logic [IR_LEN_W-1:0] ir_len,
  input  logic                eng_busy,
  input  logic                eng_done,
  input  logic [MAX_BITS-1:0] eng_result,
  output logic                req_go,
  output logic [MAX_BITS-1:0] req_word,
  output logic [LEN_W-1:0]    req_len,
  output logic [LEAD_W-1:0]   req_lead_n,
  output logic [LEAD_MAX-1:0] req_lead_pat,
  output logic                active,
  output logic                id_done,
  output logic [MAX_BITS-1:0] id_code
);
  seq_state_t          state;
  logic [IR_LEN_W-1:0] irl_q;
  logic                in_dr;

  assign in_dr        = (state == SQ_DR);
  assign active       = (state != SQ_IDLE);
  assign req_word     = in_dr ? '0 : MAX_BITS'(IDCODE_OP);
  assign req_len      = in_dr ? LEN_W'(MAX_BITS) : LEN_W'(irl_q);
  assign req_lead_n   = in_dr ? LEAD_W'(3) : LEAD_W'(4);
  assign req_lead_pat = in_dr ? PAT_TO_SHIFT_DR : PAT_TO_SHIFT_IR;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      irl_q   <= '0;
      req_go  <= 1'b0;
      id_done <= 1'b0;
      id_code <= '0;
    end else begin
      req_go  <= 1'b0;
      id_done <= 1'b0;
      unique case (state)
        SQ_IDLE: if (id_start && !eng_busy) begin
          state  <= SQ_IR;
          irl_q  <= ir_len;
          req_go <= 1'b1;
        end
        SQ_IR: if (eng_done) begin
          state  <= SQ_DR;
          req_go <= 1'b1;
        end
        SQ_DR: if (eng_done) begin
          state   <= SQ_IDLE;
          id_code <= eng_result;
          id_done <= 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/jtag_scan_master.sv
module jtag_scan_master
  import jtag_scan_pkg::*;
#(
  parameter int unsigned MAX_BITS  = 32,
  parameter int unsigned HALF_DIV  = 2,
  parameter int unsigned IR_LEN_W  = 3,
  parameter int unsigned IR_MAX    = 7,
  parameter logic [IR_MAX-1:0] IDCODE_OP = 7'h1E,
  localparam int unsigned LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [MAX_BITS-1:0] shift_word,
  input  logic [LEN_W-1:0]    shift_len,
  input  logic                lsb_first,
  input  logic                no_end,
  input  logic                no_idle,
  input  logic                id_start,
  input  logic [IR_LEN_W-1:0] ir_len,
  input  logic                tdo,
  output logic                tck,
  output logic                tms,
  output logic                tdi,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] result,
  output logic                id_done,
  output logic [MAX_BITS-1:0] id_code
);
  logic                eng_busy, rise, fall, seq_go, seq_active, ext_go, go;
  logic [MAX_BITS-1:0] seq_word, m_word;
  logic [LEN_W-1:0]    seq_len, m_len;
  logic [LEAD_W-1:0]   seq_lead_n, m_lead_n;
  logic [LEAD_MAX-1:0] seq_lead_pat;

  assign ext_go   = start && !id_start && !seq_active;
  assign go       = seq_go || ext_go;
  assign m_word   = seq_active ? seq_word   : shift_word;
  assign m_len    = seq_active ? seq_len    : shift_len;
  assign m_lead_n = seq_active ? seq_lead_n : '0;
  assign busy     = eng_busy || seq_active;

  jtag_tck_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst(rst), .en(eng_busy), .tck(tck), .rise(rise), .fall(fall)
  );

  jtag_scan_shifter #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst(rst), .go(go),
    .req_word(m_word), .req_len(m_len),
    .req_lsb(seq_active || lsb_first),
    .req_no_end(!seq_active && no_end),
    .req_no_idle(!seq_active && no_idle),
    .req_lead_n(m_lead_n), .req_lead_pat(seq_lead_pat),
    .tdo(tdo), .rise(rise), .fall(fall),
    .tms(tms), .tdi(tdi), .busy(eng_busy), .done(done), .result(result)
  );

  jtag_idcode_seq #(
    .MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .IR_LEN_W(IR_LEN_W),
    .IR_MAX(IR_MAX), .IDCODE_OP(IDCODE_OP)
  ) u_seq (
    .clk(clk), .rst(rst), .id_start(id_start), .ir_len(ir_len),
    .eng_busy(eng_busy), .eng_done(done), .eng_result(result),
    .req_go(seq_go), .req_word(seq_word), .req_len(seq_len),
    .req_lead_n(seq_lead_n), .req_lead_pat(seq_lead_pat),
    .active(seq_active), .id_done(id_done), .id_code(id_code)
  );
endmodule

// File: rtl/jtag_scan_master_chk.sv
module jtag_scan_master_chk #(
  parameter int unsigned IR_LEN_W = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                tck,
  input logic                tms,
  input logic                tdi,
  input logic                busy,
  input logic                done,
  input logic                id_start,
  input logic [IR_LEN_W-1:0] ir_len,
  input logic                id_done
);
  // R7: idle lines parked, data-in high
  p_park_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!tck && tdi));

  // R2: control lines settled before and during the high phase
  p_setup_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(tck) |-> ($stable(tms) && $stable(tdi)));

  p_setup_high_r2: assert property (@(posedge clk) disable iff (rst)
    (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi)));

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: identification result follows an engine completion
  p_id_after_done_r10: assert property (@(posedge clk) disable iff (rst)
    id_done |-> $past(done));

  // R11: only supported instruction lengths are requested
  p_irlen_r11: assert property (@(posedge clk) disable iff (rst)
    (id_start && !busy) |-> (ir_len == IR_LEN_W'(5) || ir_len == IR_LEN_W'(7)));
endmodule

bind jtag_scan_master jtag_scan_master_chk #(.IR_LEN_W(IR_LEN_W)) u_chk (
  .clk(clk), .rst(rst), .tck(tck), .tms(tms), .tdi(tdi), .busy(busy),
  .done(done), .id_start(id_start), .ir_len(ir_len), .id_done(id_done)
);

// File: tb/sim_jtag_scan_master.sv
`timescale 1ns/1ps
module sim_jtag_scan_master;
  localparam int HALF = 2;
  localparam logic [31:0] ID_VAL = 32'h5BA0_E4C7;
  localparam logic [6:0]  OPC    = 7'h1E;
  // TAP states
  localparam logic [3:0] TLR=0, RTI=1, SDS=2, CDR=3, SDR=4, E1D=5, PDR=6, E2D=7,
                         UDR=8, SIS=9, CIR=10, SIR=11, E1I=12, PIR=13, E2I=14, UIR=15;

  logic clk = 0, rst = 1;
  logic start = 0, lsb_first = 0, no_end = 0, no_idle = 0, id_start = 0, tdo = 0;
  logic [31:0] shift_word = 0;
  logic [5:0]  shift_len = 0;
  logic [2:0]  ir_len = 3'd5;
  logic tck, tms, tdi, busy, done, id_done;
  logic [31:0] result, id_code;

  int n_chk = 0, n_fail = 0;
  always #10 clk = ~clk;

  jtag_scan_master #(.HALF_DIV(HALF), .IDCODE_OP(OPC)) u0 (
    .clk(clk), .rst(rst), .start(start), .shift_word(shift_word), .shift_len(shift_len),
    .lsb_first(lsb_first), .no_end(no_end), .no_idle(no_idle), .id_start(id_start),
    .ir_len(ir_len), .tdo(tdo), .tck(tck), .tms(tms), .tdi(tdi), .busy(busy),
    .done(done), .result(result), .id_done(id_done), .id_code(id_code)
  );

  // ---------------- TAP model ----------------
  logic [3:0]  ts = TLR;
  logic [31:0] dr = 0;
  logic [6:0]  irsh = 0, ir_cur = 0;
  int          irl = 5, rises = 0;

  function automatic logic [3:0] tap_next(input logic [3:0] s, input logic m);
    case (s)
      TLR: return m ? TLR : RTI;  RTI: return m ? SDS : RTI;
      SDS: return m ? SIS : CDR;  CDR: return m ? E1D : SDR;
      SDR: return m ? E1D : SDR;  E1D: return m ? UDR : PDR;
      PDR: return m ? E2D : PDR;  E2D: return m ? UDR : SDR;
      UDR: return m ? SDS : RTI;  SIS: return m ? TLR : CIR;
      CIR: return m ? E1I : SIR;  SIR: return m ? E1I : SIR;
      E1I: return m ? UIR : PIR;  PIR: return m ? E2I : PIR;
      E2I: return m ? UIR : SIR;  default: return m ? SDS : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    rises = rises + 1;
    case (ts)
      CDR: if (ir_cur == OPC) dr <= ID_VAL;
      SDR: dr <= {tdi, dr[31:1]};
      CIR: irsh <= 7'b0000001;
      SIR: irsh <= (irl == 5) ? {2'b00, tdi, irsh[4:1]} : {tdi, irsh[6:1]};
      UIR: ir_cur <= irsh;
      default: ;
    endcase
    ts <= tap_next(ts, tms);
  end

  always @(negedge tck) begin
    if (ts == SDR) tdo <= dr[0];
    else if (ts == SIR) tdo <= irsh[0];
  end

  // ---------------- R2 phase monitor ----------------
  bit mon_en = 0;
  int mon_run = 0, mon_err = 0, mon_edges = 0;
  logic mon_prev = 0;
  always @(negedge clk) begin
    if (!busy || !mon_en) mon_run = 0;
    else if (tck != mon_prev) begin
      if (mon_run != HALF) mon_err++;
      mon_edges++;
      mon_run = 1;
    end else mon_run++;
    mon_prev = tck;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_res(input logic [31:0] d, input int n, input logic l);
    logic [31:0] r = 0;
    for (int k = 0; k < n; k++) r[l ? k : n-1-k] = d[k];
    return r;
  endfunction

  function automatic logic [31:0] exp_dr(input logic [31:0] d, input logic [31:0] w, input int n, input logic l);
    logic [31:0] r = (n >= 32) ? 32'h0 : (d >> n);
    for (int k = 0; k < n; k++) r[32-n+k] = l ? w[k] : w[n-1-k];
    return r;
  endfunction

  task automatic preset_sdr(input logic [31:0] v);
    ts = SDR; dr = v; tdo = v[0]; rises = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic wait_id(output bit ok);
    ok = 0;
    for (int i = 0; i < 10000; i++) begin
      if (id_done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic xfer(input logic [31:0] w, input int n, input logic l, input logic ne,
                      input logic ni, output logic [31:0] res, output bit ok);
    @(negedge clk);
    shift_word = w; shift_len = 6'(n); lsb_first = l; no_end = ne; no_idle = ni; start = 1;
    @(negedge clk);
    start = 0;
    wait_done(ok);
    res = result;
  endtask

  // {word, dr_init, len, lsb, no_end, no_idle}
  localparam logic [72:0] VEC [0:6] = '{
    {32'hA5C3_1E0F, 32'h1357_9BDF, 6'd8,  1'b1, 1'b0, 1'b0},
    {32'h0000_0155, 32'hFEDC_BA98, 6'd11, 1'b0, 1'b0, 1'b0},
    {32'hDEAD_BEEF, 32'h0F0F_3C3C, 6'd32, 1'b1, 1'b0, 1'b1},
    {32'h8000_0001, 32'h6B2D_91E4, 6'd32, 1'b0, 1'b0, 1'b0},
    {32'h0000_0001, 32'h0000_0002, 6'd1,  1'b1, 1'b0, 1'b0},
    {32'h0000_002A, 32'hC001_D00D, 6'd6,  1'b0, 1'b1, 1'b0},
    {32'h0000_0003, 32'h0000_0005, 6'd2,  1'b1, 1'b1, 1'b1}
  };

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] res, e, d0;
    bit ok;
    int cnt, n;
    logic l, ne, ni;
    logic [3:0] est;
    string tg;

    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!tck && !tms && tdi && !busy && !done, "R1 idle lines",
        {27'b0, tck, tms, tdi, busy, done}, 32'h4);
    chk(result == 0 && id_code == 0 && !id_done, "R1 result regs", result | id_code, 32'h0);

    // ---- vector table ----
    for (int i = 0; i < 7; i++) begin
      d0 = VEC[i][40:9]; n = int'(VEC[i][8:3]);
      l = VEC[i][2]; ne = VEC[i][1]; ni = VEC[i][0];
      preset_sdr(d0);
      mon_en = 1;
      xfer(VEC[i][72:41], n, l, ne, ni, res, ok);
      mon_en = 0;
      tg = l ? "R3" : "R4";
      chk(ok, {tg, " done seen"}, 32'(ok), 32'h1);
      e = exp_res(d0, n, l);
      chk(res == e, {tg, " captured word"}, res, e);
      e = exp_dr(d0, VEC[i][72:41], n, l);
      chk(dr == e, {tg, " target register"}, dr, e);
      est = ne ? SDR : (ni ? UDR : RTI);
      tg = ne ? "R6" : "R5";
      chk(ts == est, {tg, " final TAP state"}, 32'(ts), 32'(est));
      cnt = n + (ne ? 0 : (ni ? 1 : 2));
      chk(rises == cnt, {tg, " tck count"}, 32'(rises), 32'(cnt));
      chk(tdi && !busy, "R7 tdi parked", {30'b0, tdi, busy}, 32'h2);
      @(negedge clk);
      chk(!done, "R8 done single cycle", 32'(done), 32'h0);
    end
    chk(mon_err == 0 && mon_edges > 100, "R2 tck phase length", 32'(mon_err), 32'h0);

    // ---- chained transfer, R6 ----
    preset_sdr(32'h9C3E_71A5);
    xfer(32'h0000_BEEF, 16, 1, 1, 0, res, ok);
    chk(ts == SDR && res == 32'h0000_71A5, "R6 chain first half", res, 32'h71A5);
    xfer(32'h0000_CAFE, 16, 1, 0, 0, res, ok);
    chk(dr == 32'hCAFE_BEEF, "R6 chain register", dr, 32'hCAFE_BEEF);
    chk(res == 32'h0000_9C3E && ts == RTI, "R6 chain second half", res, 32'h9C3E);

    // ---- start while busy, R9 ----
    preset_sdr(32'h0F0F_0F0F);
    @(negedge clk);
    shift_word = 32'h1111_2222; shift_len = 6'd12; lsb_first = 1; no_end = 0; no_idle = 0; start = 1;
    @(negedge clk); start = 0;
    repeat (6) @(negedge clk);
    shift_word = 32'hFFFF_FFFF; shift_len = 6'd3; start = 1;
    @(negedge clk); start = 0;
    wait_done(ok);
    chk(result == 32'h0000_0F0F, "R9 busy start ignored result", result, 32'hF0F);
    e = exp_dr(32'h0F0F_0F0F, 32'h1111_2222, 12, 1);
    chk(dr == e, "R9 busy start ignored register", dr, e);
    cnt = 0;
    repeat (100) begin @(negedge clk); if (done || busy) cnt++; end
    chk(cnt == 0, "R9 no second transfer", 32'(cnt), 32'h0);

    // ---- bad lengths, R9 ----
    rises = 0;
    foreach (shift_len[k]) ; // no-op
    for (int b = 0; b < 2; b++) begin
      @(negedge clk);
      shift_len = (b == 0) ? 6'd0 : 6'd33; start = 1;
      @(negedge clk); start = 0;
      cnt = 0;
      repeat (30) begin @(negedge clk); if (busy || done) cnt++; end
      chk(cnt == 0 && rises == 0, "R9 bad length ignored", 32'(cnt), 32'h0);
    end

    // ---- identification reads, R10/R11 ----
    for (int v = 0; v < 2; v++) begin
      ts = RTI; ir_cur = 0; rises = 0;
      irl = (v == 0) ? 5 : 7;
      @(negedge clk);
      ir_len = 3'(irl); id_start = 1;
      @(negedge clk); id_start = 0;
      wait_id(ok);
      chk(ok && id_code == ID_VAL, "R10 id code", id_code, ID_VAL);
      chk(ts == RTI && ir_cur == OPC, "R10 end state and opcode", {21'b0, ts, ir_cur}, {21'b0, RTI, OPC});
      chk(rises == 43 + irl, "R11 id tck count", 32'(rises), 32'(43 + irl));
      @(negedge clk);
      chk(!id_done && !busy, "R10 id_done single cycle", {30'b0, id_done, busy}, 32'h0);
    end

    // ---- start and id_start together, R12 ----
    ts = RTI; ir_cur = 0; rises = 0; irl = 5;
    @(negedge clk);
    ir_len = 3'd5; id_start = 1; start = 1; shift_word = 32'h1234_5678; shift_len = 6'd20;
    @(negedge clk); id_start = 0; start = 0;
    wait_id(ok);
    chk(ok && id_code == ID_VAL && rises == 48, "R12 id wins over start", 32'(rises), 32'd48);

    // ---- id_start while busy, R12 ----
    preset_sdr(32'h3333_4444);
    @(negedge clk);
    shift_word = 32'h0; shift_len = 6'd32; lsb_first = 1; start = 1;
    @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    id_start = 1;
    @(negedge clk); id_start = 0;
    wait_done(ok);
    chk(result == 32'h3333_4444, "R12 transfer unaffected", result, 32'h3333_4444);
    cnt = 0;
    repeat (300) begin @(negedge clk); if (id_done || busy) cnt++; end
    chk(cnt == 0 && rises == 34, "R12 busy id_start ignored", 32'(rises), 32'd34);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule